// File: doc/BRIEF.md
# Even/Odd Bank Access Splitter

This block sits between a processor's data-access requests and a sequencer that runs single 16-bit bus cycles. A request carries a segment, an offset, a byte-or-word size, a direction and write data. The block forms a 20-bit physical address by shifting the segment left four places and adding the offset. It drives the two bank selects: address bit 0 for the low (even) bank, and an active-low high-byte enable for the high (odd) bank. It also moves each byte onto the data lane of the bank that owns it.

A word at an even address goes out as one bus cycle with both banks enabled. A word at an odd address spans both banks. It is split into two byte cycles: the low byte goes first, through the odd bank at the computed address, and the high byte follows through the even bank at the next address. Read bytes are gathered into one word. The requester sees `up_ready` only once every bus cycle of its request has completed.

Top module: `bank_splitter`

## Requirements
- R1: The physical address equals (segment × 16 + offset) modulo 2^20, so a sum past 0xFFFFF wraps to the bottom of the space.
- R2: A word at an even address takes exactly one bus cycle, with bus_addr[0]=0, bus_bhe_n=0 and the 16-bit write data passed unchanged (bits 7:0 on the low lane).
- R3: A byte at an even address takes one bus cycle with bus_bhe_n=1. The read result is the low lane (bits 7:0) zero-extended to 16 bits.
- R4: A byte at an odd address takes one bus cycle with bus_addr[0]=1 and bus_bhe_n=0. The read result is the high lane (bits 15:8) zero-extended.
- R5: A word at an odd address takes exactly two bus cycles. The first uses the computed address with bus_bhe_n=0 and carries the low byte on bits 15:8. The second uses the next address with bus_bhe_n=1 and carries the high byte on bits 7:0.
- R6: The +1 address of the second cycle of a split word wraps modulo 2^20 (0xFFFFF is followed by 0x00000).
- R7: up_ready is a one-cycle pulse, raised in the cycle after the last bus_done of the request and never while bus_req is high. On a read, up_rdata then holds the byte from the computed address in bits 7:0 and the byte from the next address in bits 15:8.
- R8: Every byte cycle places the transferred byte on both lanes, bus_wdata = {b, b}. bus_write always equals the request's direction (1 = write).
- R9: While rst_n is low (synchronous), and in the cycle after it, bus_req and up_ready are 0. A reset in the middle of a request abandons it.
- R10: While bus_req is high and bus_done is low, bus_req stays high and bus_addr, bus_bhe_n, bus_write and bus_wdata hold steady (wait states).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_req | input | 1 | Request held high until up_ready |
| up_write | input | 1 | 1 = write, 0 = read |
| up_word | input | 1 | 1 = 16-bit word, 0 = byte (bits 7:0) |
| up_seg | input | 16 | Segment value |
| up_off | input | 16 | Offset value |
| up_wdata | input | 16 | Write data |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | 16 | Assembled read data, valid with up_ready |
| bus_req | output | 1 | Bus-cycle request to the sequencer |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | 20 | Physical address; bit 0 is the even-bank select (active low) |
| bus_bhe_n | output | 1 | High-bank enable, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from the sequencer, taken with bus_done |
| bus_done | input | 1 | Completion of the current bus cycle |

## Verification
The bench builds the block with its default parameters: a 16-bit segment shifted by 4, a 16-bit offset and a 20-bit address. With these values, segment 0xFFFF with a small offset reaches both wrap cases: the wrap while forming the address, and the wrap of the +1 in a split word at 0xFFFFF. Offset 0xFFFF with segment 0 crosses a 64 KB boundary inside a split. The sequencer model answers after zero to two wait cycles, so the hold behaviour during waits and the placement of the ready pulse are both observed.

// File: rtl/bank_splitter_pkg.sv
// Shared types for the bank splitter.
// Assumes: one request in flight at a time.
package bank_splitter_pkg;

    // Sequencing phase of one upstream request.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_FINISH = 2'd3
    } phase_t;

endpackage

// File: rtl/bank_splitter_addr.sv
// Forms the physical address as (segment << SHIFT) + offset, truncated to
// ADDR_W bits.
// Assumes: SEG_W + SHIFT >= ADDR_W and ADDR_W > OFF_W.
module bank_splitter_addr #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    localparam int EXT_W = SEG_W + SHIFT;

    logic [EXT_W-1:0] seg_ext;

    // Shift the segment, then add the zero-extended offset; the carry out is dropped.
    always_comb begin
        seg_ext = {seg, {SHIFT{1'b0}}};
        phys    = seg_ext[ADDR_W-1:0] + {{(ADDR_W-OFF_W){1'b0}}, off};
    end

endmodule

// File: rtl/bank_splitter_lanes.sv
// Byte-lane steering for one bus cycle: high-bank enable, write-lane data
// and selection of the read byte.
// Assumes: two lanes of BYTE_W bits; lane 0 = even bank, lane 1 = odd bank.
module bank_splitter_lanes #(
    parameter int BYTE_W = 8
) (
    input  logic                  addr0,
    input  logic                  word,
    input  logic                  second,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0]   rdata,
    output logic                  bhe_n,
    output logic [2*BYTE_W-1:0]   lane_wdata,
    output logic [BYTE_W-1:0]     rd_byte
);
    localparam int LANES = 2;

    logic             full_word;
    logic [BYTE_W-1:0] tx_byte;

    // Classify the cycle and choose the byte it carries.
    always_comb begin
        full_word = word && !addr0 && !second;
        tx_byte   = second ? wdata[BYTE_W +: BYTE_W] : wdata[0 +: BYTE_W];
        bhe_n     = !(addr0 || full_word);
        rd_byte   = addr0 ? rdata[BYTE_W +: BYTE_W] : rdata[0 +: BYTE_W];
    end

    // Fill every lane: a full word keeps its own byte on each lane, a byte cycle repeats its byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_wdata[l*BYTE_W +: BYTE_W] = full_word ? wdata[l*BYTE_W +: BYTE_W] : tx_byte;
    end

endmodule

// File: rtl/bank_splitter_ctrl.sv
// Request sequencer: latches a request, issues one or two bus cycles,
// assembles the read word and pulses ready at the end.
// Assumes: up_req stays high until up_ready, and bus_done arrives only while bus_req is high.
module bank_splitter_ctrl
    import bank_splitter_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_req,
    input  logic                up_write,
    input  logic                up_word,
    input  logic [ADDR_W-1:0]   phys_in,
    input  logic [2*BYTE_W-1:0] up_wdata,
    output logic                up_ready,
    output logic [2*BYTE_W-1:0] up_rdata,
    output logic                bus_req,
    output logic                bus_write,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                cyc_second,
    output logic                cyc_word,
    output logic [2*BYTE_W-1:0] cyc_wdata,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0]   rd_byte,
    input  logic                bus_done
);
    localparam int DATA_W = 2*BYTE_W;

    phase_t              phase_q;
    logic [ADDR_W-1:0]   phys_q;
    logic                word_q;
    logic                write_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                split;

    // A word at an odd address needs a second cycle.
    assign split = word_q && phys_q[0];

    // Advance the phase and capture request fields and read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            phys_q  <= '0;
            word_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (up_req) begin
                    phys_q  <= phys_in;
                    word_q  <= up_word;
                    write_q <= up_write;
                    wdata_q <= up_wdata;
                    phase_q <= PH_FIRST;
                end
                PH_FIRST: if (bus_done) begin
                    if (word_q && !phys_q[0]) rdata_q <= bus_rdata;
                    else                      rdata_q <= {{BYTE_W{1'b0}}, rd_byte};
                    phase_q <= split ? PH_SECOND : PH_FINISH;
                end
                PH_SECOND: if (bus_done) begin
                    rdata_q[DATA_W-1:BYTE_W] <= rd_byte;
                    phase_q <= PH_FINISH;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Present the current bus cycle from the latched request.
    always_comb begin
        cyc_second = (phase_q == PH_SECOND);
        bus_req    = (phase_q == PH_FIRST) || cyc_second;
        bus_addr   = cyc_second ? phys_q + ADDR_W'(1) : phys_q;
        bus_write  = write_q;
        cyc_word   = word_q;
        cyc_wdata  = wdata_q;
        up_ready   = (phase_q == PH_FINISH);
        up_rdata   = rdata_q;
    end

    // R6: the second cycle of a split word uses the address after the first, modulo 2^ADDR_W.
    a_r6_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FIRST && bus_done && split) |=> (bus_req && bus_addr == $past(bus_addr) + ADDR_W'(1)));

    // R7: ready is a single-cycle pulse and never overlaps a bus request.
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |=> !up_ready);
    a_r7_ready_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> !bus_req);

    // R9: nothing is requested or acknowledged in the cycle after reset.
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !up_ready));

endmodule

// File: rtl/bank_splitter.sv
// Top of the even/odd bank splitter: address formation, the request
// sequencer and byte-lane steering.
// Assumes: a downstream sequencer that runs one bus cycle per bus_req and signals it with bus_done.
module bank_splitter #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_req,
    input  logic                up_write,
    input  logic                up_word,
    input  logic [SEG_W-1:0]    up_seg,
    input  logic [OFF_W-1:0]    up_off,
    input  logic [2*BYTE_W-1:0] up_wdata,
    output logic                up_ready,
    output logic [2*BYTE_W-1:0] up_rdata,
    output logic                bus_req,
    output logic                bus_write,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_bhe_n,
    output logic [2*BYTE_W-1:0] bus_wdata,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    input  logic                bus_done
);
    localparam int DATA_W = 2*BYTE_W;

    logic [ADDR_W-1:0] phys;
    logic              cyc_second;
    logic              cyc_word;
    logic [DATA_W-1:0] cyc_wdata;
    logic [BYTE_W-1:0] rd_byte;

    bank_splitter_addr #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
    ) addr_i (
        .seg (up_seg),
        .off (up_off),
        .phys(phys)
    );

    bank_splitter_ctrl #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .up_write  (up_write),
        .up_word   (up_word),
        .phys_in   (phys),
        .up_wdata  (up_wdata),
        .up_ready  (up_ready),
        .up_rdata  (up_rdata),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cyc_second(cyc_second),
        .cyc_word  (cyc_word),
        .cyc_wdata (cyc_wdata),
        .bus_rdata (bus_rdata),
        .rd_byte   (rd_byte),
        .bus_done  (bus_done)
    );

    bank_splitter_lanes #(
        .BYTE_W(BYTE_W)
    ) lanes_i (
        .addr0     (bus_addr[0]),
        .word      (cyc_word),
        .second    (cyc_second),
        .wdata     (cyc_wdata),
        .rdata     (bus_rdata),
        .bhe_n     (bus_bhe_n),
        .lane_wdata(bus_wdata),
        .rd_byte   (rd_byte)
    );

    // R4: an odd address always enables the high bank.
    a_r4_odd_uses_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr[0]) |-> !bus_bhe_n);

    // R10: the bus cycle holds steady through wait states.
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_bhe_n)
                                    && $stable(bus_write) && $stable(bus_wdata)));

endmodule

// File: tb/bank_splitter_tb_top.sv
`timescale 1ns/1ps
module bank_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_write = 1'b0, up_word = 1'b0;
    logic [15:0] up_seg = '0, up_off = '0, up_wdata = '0;
    logic        up_ready;
    logic [15:0] up_rdata;
    logic        bus_req, bus_write, bus_bhe_n;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_done = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    bank_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_write(up_write), .up_word(up_word),
        .up_seg(up_seg), .up_off(up_off), .up_wdata(up_wdata), .up_ready(up_ready),
        .up_rdata(up_rdata), .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done)
    );

    // Vector: write, word, segment, offset, write data, wait cycles.
    localparam int NV = 12;
    localparam logic [51:0] VECS [NV] = '{
        {1'b0, 1'b1, 16'h1234, 16'h0010, 16'h0000, 2'd0},
        {1'b0, 1'b1, 16'h1000, 16'h0003, 16'h0000, 2'd1},
        {1'b0, 1'b0, 16'h0800, 16'h0042, 16'h0000, 2'd0},
        {1'b0, 1'b0, 16'h0800, 16'h0043, 16'h0000, 2'd2},
        {1'b1, 1'b1, 16'h2000, 16'h0100, 16'hBEEF, 2'd0},
        {1'b1, 1'b1, 16'h2000, 16'h0101, 16'hCAFE, 2'd1},
        {1'b1, 1'b0, 16'h3000, 16'h0004, 16'h00A5, 2'd0},
        {1'b1, 1'b0, 16'h3000, 16'h0005, 16'h005A, 2'd0},
        {1'b0, 1'b1, 16'hFFFF, 16'h000F, 16'h0000, 2'd0},
        {1'b0, 1'b0, 16'hFFFF, 16'h0012, 16'h0000, 2'd0},
        {1'b1, 1'b1, 16'hFFFF, 16'h000F, 16'h1357, 2'd1},
        {1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'h0000, 2'd0}
    };

    logic [19:0] rec_addr [4];
    logic        rec_bhe  [4];
    logic        rec_wr   [4];
    logic [15:0] rec_wd   [4];
    int          rec_n;
    logic [15:0] got_rdata;
    bit          got_ready;

    function automatic logic [7:0] mem_b(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request and play the bus sequencer until ready.
    task automatic run_txn(input logic wr, input logic wd, input logic [15:0] sg,
                           input logic [15:0] of, input logic [15:0] dat, input int lat);
        rec_n = 0; got_ready = 0; got_rdata = '0;
        up_write = wr; up_word = wd; up_seg = sg; up_off = of; up_wdata = dat; up_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            if (up_ready) begin
                got_ready = 1; got_rdata = up_rdata; up_req = 1'b0;
                @(negedge clk);
                chk("R7 ready single pulse", {31'd0, up_ready}, 32'd0);
                break;
            end
            if (bus_req) begin
                if (rec_n < 4) begin
                    rec_addr[rec_n] = bus_addr; rec_bhe[rec_n] = bus_bhe_n;
                    rec_wr[rec_n] = bus_write;  rec_wd[rec_n] = bus_wdata;
                end
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    chk("R10 address held in wait", {12'd0, bus_addr}, {12'd0, rec_addr[rec_n]});
                end
                bus_rdata = {mem_b({bus_addr[19:1], 1'b1}), mem_b({bus_addr[19:1], 1'b0})};
                bus_done = 1'b1;
                rec_n++;
                @(negedge clk);
                bus_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: idle outputs under reset.
        chk("R9 bus_req in reset", {31'd0, bus_req}, 32'd0);
        chk("R9 up_ready in reset", {31'd0, up_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic        wr, wd, odd;
            logic [15:0] sg, of, dat;
            int          lat, ncyc;
            logic [19:0] phys;
            logic [15:0] exp_wd0, exp_rd;
            string       tag;
            {wr, wd, sg, of, dat} = VECS[v][51:2];
            lat  = int'(VECS[v][1:0]);
            phys = 20'({sg, 4'h0} + {4'h0, of});
            odd  = phys[0];
            ncyc = (wd && odd) ? 2 : 1;
            tag  = wd ? (odd ? "R5" : "R2") : (odd ? "R4" : "R3");
            run_txn(wr, wd, sg, of, dat, lat);
            chk({tag, " R7 ready seen"}, {31'd0, got_ready}, 32'd1);
            chk({tag, " bus cycle count"}, rec_n, ncyc);
            chk({"R1 ", tag, " first address"}, {12'd0, rec_addr[0]}, {12'd0, phys});
            chk({tag, " first bhe_n"}, {31'd0, rec_bhe[0]}, {31'd0, !(odd || wd)});
            chk({"R8 ", tag, " direction"}, {31'd0, rec_wr[0]}, {31'd0, wr});
            if (wr) begin
                exp_wd0 = (wd && !odd) ? dat : {dat[7:0], dat[7:0]};
                chk({"R8 ", tag, " first write lanes"}, {16'd0, rec_wd[0]}, {16'd0, exp_wd0});
            end
            if (ncyc == 2 && rec_n == 2) begin
                chk("R5 R6 second address", {12'd0, rec_addr[1]}, {12'd0, phys + 20'd1});
                chk("R5 second bhe_n", {31'd0, rec_bhe[1]}, 32'd1);
                if (wr) chk("R5 R8 second write lanes", {16'd0, rec_wd[1]}, {16'd0, dat[15:8], dat[15:8]});
            end
            if (!wr) begin
                exp_rd = wd ? {mem_b(phys + 20'd1), mem_b(phys)} : {8'h00, mem_b(phys)};
                chk({"R7 ", tag, " read data"}, {16'd0, got_rdata}, {16'd0, exp_rd});
            end
        end

        // R9: reset in the middle of a split word abandons it.
        up_write = 1'b0; up_word = 1'b1; up_seg = 16'h0100; up_off = 16'h0001; up_req = 1'b1;
        @(negedge clk);
        chk("R9 split started", {31'd0, bus_req}, 32'd1);
        rst_n = 1'b0; up_req = 1'b0;
        @(negedge clk);
        chk("R9 bus_req after reset", {31'd0, bus_req}, 32'd0);
        chk("R9 up_ready after reset", {31'd0, up_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stays idle", {31'd0, bus_req}, 32'd0);

        if (!ended) begin
            ended = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(200000 * 8);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule